// File: doc/BRIEF.md
# Two-Register Accumulator Processor Core

This block is a compact 16-bit multi-cycle processor. It has two working registers, a 6-bit program counter and a single 64-word memory. That memory holds both the program and its data. Every instruction word puts a 6-bit opcode in bits 15:10 and a 10-bit operand in bits 9:0. Only operand bits 5:0 select a memory word. The core can load, store, add, shift left, invert, increment, branch on a zero register, jump, emit a register value and stop.

The memory is filled through a write port while `rst` is held high. Releasing reset starts execution at address 0. Each instruction runs in three states. The fetch state reads the word at the program counter. The decode state latches the instruction and reads its operand word. The execute state updates the registers, the memory, the program counter or the output.

Values leave on a valid/ready stream. `out_valid` rises only in the execute state of an output instruction. While `out_ready` is low, the core stalls in that state, and `out_valid` and `out_data` hold steady. The word transfers on the first edge where both signals are high, and the core then fetches the next instruction. `halted` is a plain status level. A write through the load port in the same cycle as a store instruction wins over the store.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, both registers and `halted`, and keeps `out_valid` low. Memory contents survive reset.
- R2: With `ld_we` high, the word `ld_data` is written to address `ld_addr` at the clock edge.
- R3: The opcode is bits 15:10 and the operand is bits 9:0. Operand bits 9:6 are ignored when addressing memory.
- R4: Opcodes 0 and 8 load the addressed word into register 1 or register 2. Opcodes 3 and 11 add the addressed word to that register, wrapping modulo 2^16.
- R5: Opcodes 4 and 12 shift the register left by one, fill bit 0 with 0 and drop bit 15. Opcodes 5 and 13 invert the register. Opcode 17 increments register 1 modulo 2^16.
- R6: Opcodes 1 and 9 write register 1 or register 2 to the addressed word.
- R7: Opcode 6 jumps to the operand address. Opcodes 2 and 10 jump only when register 1 or register 2 is zero, and otherwise fall through.
- R8: Opcode 14 presents register 1 and opcode 15 presents register 2 on `out_data` with `out_valid` high.
- R9: While `out_valid` is high and `out_ready` low, the core stalls with `out_valid` and `out_data` unchanged. After a transfer, `out_valid` is low in the next cycle.
- R10: Opcode 7 raises `halted`, which stays high until reset. After that the program counter is frozen and no further output appears.
- R11: Opcodes 16, 18 to 31 and 32 to 63 change no register and no memory word. They only advance the program counter.
- R12: The program counter wraps from 63 to 0.
- R13: Each instruction that does not stall takes exactly three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Memory load strobe |
| ld_addr | input | 6 | Memory load address |
| ld_data | input | 16 | Memory load word |
| out_data | output | 16 | Emitted register value |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts output word |
| halted | output | 1 | Core has executed stop |

## Verification
The arithmetic opcodes are tried on a table of operand pairs. The table includes carries out of bit 15, a set top bit before a shift and all-ones before an increment, so correct wrapping can be told apart from saturation or a stray carry. The table also runs reserved and undefined opcodes, and opcodes of one register while watching the other, which shows whether a no-op or a wrong register write has corrupted state. Branch programs run with a zero and a nonzero register, and one program starts near address 63, to tell a taken branch from a fall-through and to show that the counter wraps. A running sequence program is checked for its values and for its output spacing. The same program is then run with the consumer stalled, to check that output holds under back-pressure.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_HALT
  } cpu_state_e;

  typedef enum logic [3:0] {
    K_NOP,
    K_LOAD,
    K_STORE,
    K_JZ,
    K_ADD,
    K_SHL,
    K_NOT,
    K_JMP,
    K_STOP,
    K_OUT,
    K_INC
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     rsel;
  } ctl_t;

  localparam int unsigned OP_INC_R1 = 17;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_cpu_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic [OPW-1:0] opcode,
  output ctl_t           ctl
);

  always_comb begin
    ctl.kind = K_NOP;
    ctl.rsel = 1'b0;
    if (opcode[OPW-1:4] == '0) begin
      if (opcode[3:1] == 3'b111) begin
        ctl.kind = K_OUT;
        ctl.rsel = opcode[0];
      end else begin
        ctl.rsel = opcode[3];
        unique case (opcode[2:0])
          3'd0: ctl.kind = K_LOAD;
          3'd1: ctl.kind = K_STORE;
          3'd2: ctl.kind = K_JZ;
          3'd3: ctl.kind = K_ADD;
          3'd4: ctl.kind = K_SHL;
          3'd5: ctl.kind = K_NOT;
          3'd6: ctl.kind = K_JMP;
          3'd7: ctl.kind = K_STOP;
          default: ctl.kind = K_NOP;
        endcase
      end
    end else if (opcode == OPW'(OP_INC_R1)) begin
      ctl.kind = K_INC;
      ctl.rsel = 1'b0;
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_kind_e        kind,
  input  logic [DW-1:0]   reg_val,
  input  logic [DW-1:0]   mem_val,
  output logic [DW-1:0]   result
);

  always_comb begin
    unique case (kind)
      K_LOAD:  result = mem_val;
      K_ADD:   result = reg_val + mem_val;
      K_SHL:   result = {reg_val[DW-2:0], 1'b0};
      K_NOT:   result = ~reg_val;
      K_INC:   result = reg_val + DW'(1);
      default: result = reg_val;
    endcase
  end

endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
    rdata <= store_q[raddr];
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 6,
  parameter int OPW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          halted
);

  localparam int NREG = 2;

  cpu_state_e     state_q, state_d;
  logic [AW-1:0]  pc_q, pc_d;
  logic [OPW-1:0] ir_op_q;
  logic [AW-1:0]  ir_addr_q;
  logic [DW-1:0]  regs_q [NREG];

  logic [AW-1:0]  mem_raddr;
  logic [DW-1:0]  mem_rdata;
  logic           mem_we;
  logic [AW-1:0]  mem_waddr;
  logic [DW-1:0]  mem_wdata;
  logic           core_store;

  ctl_t           ctl;
  logic [DW-1:0]  sel_val;
  logic [DW-1:0]  alu_y;
  logic           reg_we;
  logic           take_branch;

  acc_mem #(.DW(DW), .AW(AW)) i_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  acc_decode #(.OPW(OPW)) i_decode (
    .opcode (ir_op_q),
    .ctl    (ctl)
  );

  assign sel_val = regs_q[ctl.rsel];

  acc_alu #(.DW(DW)) i_alu (
    .kind    (ctl.kind),
    .reg_val (sel_val),
    .mem_val (mem_rdata),
    .result  (alu_y)
  );

  // The external load port has priority over a store instruction.
  assign mem_we    = ld_we | core_store;
  assign mem_waddr = ld_we ? ld_addr : ir_addr_q;
  assign mem_wdata = ld_we ? ld_data : sel_val;

  assign take_branch = (ctl.kind == K_JMP) ||
                       ((ctl.kind == K_JZ) && (sel_val == '0));

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    mem_raddr  = pc_q;
    core_store = 1'b0;
    reg_we     = 1'b0;
    out_valid  = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        mem_raddr = pc_q;
        pc_d      = pc_q + AW'(1);
        state_d   = ST_DECODE;
      end
      ST_DECODE: begin
        mem_raddr = mem_rdata[AW-1:0];
        state_d   = ST_EXEC;
      end
      ST_EXEC: begin
        mem_raddr = ir_addr_q;
        state_d   = ST_FETCH;
        if (take_branch) begin
          pc_d = ir_addr_q;
        end
        unique case (ctl.kind)
          K_LOAD, K_ADD, K_SHL, K_NOT, K_INC: reg_we = 1'b1;
          K_STORE: core_store = 1'b1;
          K_STOP:  state_d = ST_HALT;
          K_OUT: begin
            out_valid = 1'b1;
            if (!out_ready) begin
              state_d = ST_EXEC;
            end
          end
          default: ;
        endcase
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_FETCH;
      pc_q      <= '0;
      ir_op_q   <= '0;
      ir_addr_q <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      if (state_q == ST_DECODE) begin
        ir_op_q   <= mem_rdata[DW-1 -: OPW];
        ir_addr_q <= mem_rdata[AW-1:0];
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (reg_we && (int'(ctl.rsel) == g)) begin
        regs_q[g] <= alu_y;
      end
    end
  end

  assign out_data = sel_val;
  assign halted   = (state_q == ST_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic          halted,
  input logic [AW-1:0] pc
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!halted && !out_valid && pc == '0)); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid); // R9

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R10

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    halted |-> !out_valid); // R10

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc)); // R10

endmodule

bind acc_cpu_core acc_cpu_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .halted    (halted),
  .pc        (pc_q)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          halted;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  acc_cpu_core i_acc_cpu_core (
    .clk       (clk),
    .rst       (rst),
    .ld_we     (ld_we),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .halted    (halted)
  );

  // {opcode, register select, word A, word B, expected, requirement}
  localparam logic [58:0] VEC [NV] = '{
    {6'd3,  1'b0, 16'h1234, 16'h0F0F, 16'h2143, 4'd4},  // R4 add r1
    {6'd3,  1'b0, 16'hFFFF, 16'h0002, 16'h0001, 4'd4},  // R4 wrap
    {6'd11, 1'b1, 16'h8000, 16'h8000, 16'h0000, 4'd4},  // R4 add r2 wrap
    {6'd11, 1'b1, 16'h0101, 16'h0202, 16'h0303, 4'd4},  // R4
    {6'd4,  1'b0, 16'h8001, 16'h0000, 16'h0002, 4'd5},  // R5 shl drops msb
    {6'd12, 1'b1, 16'hC003, 16'h0000, 16'h8006, 4'd5},  // R5
    {6'd5,  1'b0, 16'h00FF, 16'h0000, 16'hFF00, 4'd5},  // R5 not
    {6'd13, 1'b1, 16'hAAAA, 16'h0000, 16'h5555, 4'd5},  // R5
    {6'd17, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 4'd5},  // R5 incr wrap
    {6'd17, 1'b0, 16'h0041, 16'h0000, 16'h0042, 4'd5},  // R5
    {6'd0,  1'b1, 16'h1357, 16'h2468, 16'h1357, 4'd4},  // R4 load r1 leaves r2
    {6'd8,  1'b0, 16'h1357, 16'h2468, 16'h1357, 4'd4},  // R4 load r2 leaves r1
    {6'd16, 1'b0, 16'h0BEE, 16'h1111, 16'h0BEE, 4'd11}, // R11
    {6'd18, 1'b0, 16'h0007, 16'h1111, 16'h0007, 4'd11}, // R11
    {6'd19, 1'b0, 16'h00F0, 16'h0FF0, 16'h00F0, 4'd11}, // R11
    {6'd20, 1'b0, 16'h00F0, 16'h0FF0, 16'h00F0, 4'd11}, // R11
    {6'd23, 1'b0, 16'h4321, 16'h0001, 16'h4321, 4'd11}, // R11
    {6'd25, 1'b1, 16'h0009, 16'h0000, 16'h0009, 4'd11}, // R11
    {6'd28, 1'b1, 16'h0F0F, 16'hFFFF, 16'h0F0F, 4'd11}, // R11
    {6'd63, 1'b1, 16'h7777, 16'h0001, 16'h7777, 4'd11}  // R11
  };

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input int op, input int opnd);
    logic [5:0] o = op[5:0];
    logic [9:0] a = opnd[9:0];
    return {o, a};
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_we   = 1'b1;
    ld_addr = a[AW-1:0];
    ld_data = d;
    @(negedge clk);
    ld_we   = 1'b0;
  endtask

  task automatic hold_and_clear();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) wr(i, ins(16, 0));
  endtask

  task automatic go();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_out(output logic [DW-1:0] d, output int t, output bit got);
    got = 1'b0;
    d   = '0;
    t   = 0;
    for (int k = 0; k < 600 && !got; k++) begin
      @(negedge clk);
      if (out_valid) begin
        got = 1'b1;
        d   = out_data;
        t   = cyc;
      end
    end
  endtask

  task automatic wait_halt(output bit got);
    got = 1'b0;
    for (int k = 0; k < 600 && !got; k++) begin
      @(negedge clk);
      if (halted) got = 1'b1;
    end
  endtask

  task automatic load_fib();
    hold_and_clear();
    wr(0, ins(0, 13));
    wr(1, ins(3, 15));
    wr(2, ins(14, 0));
    wr(3, ins(1, 15));
    wr(4, ins(3, 14));
    wr(5, ins(14, 0));
    wr(6, ins(1, 14));
    wr(7, ins(6, 1));
    wr(13, 16'd0);
    wr(14, 16'd1);
    wr(15, 16'd1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] exp;
    int t;
    int t_prev;
    bit got;
    logic [5:0] v_op;
    logic v_rs;
    logic [DW-1:0] v_a, v_b, v_e;
    logic [3:0] v_req;
    logic [DW-1:0] fib [8];

    // R1: state while reset is held
    repeat (3) @(negedge clk);
    check(!halted && !out_valid, "R1 reset outputs", {14'd0, halted, out_valid}, '0);

    // Table walk. R3: the load operand carries 4'b1010 in bits 9:6.
    for (int v = 0; v < NV; v++) begin
      {v_op, v_rs, v_a, v_b, v_e, v_req} = VEC[v];
      hold_and_clear();
      wr(0, ins(v_rs ? 8 : 0, 10'h280 | 20));
      wr(1, ins(int'(v_op), 21));
      wr(2, ins(v_rs ? 15 : 14, 0));
      wr(3, ins(7, 0));
      wr(20, v_a);
      wr(21, v_b);
      go();
      wait_out(d, t, got);
      check(got && d == v_e, $sformatf("R%0d/R3 vector %0d", v_req, v), d, v_e);
      wait_halt(got);
      check(got, $sformatf("R10 vector %0d halt", v), {15'd0, halted}, 16'd1);
    end

    // R8 R13 R9: sequence program with free-running consumer
    fib = '{16'd1, 16'd2, 16'd3, 16'd5, 16'd8, 16'd13, 16'd21, 16'd34};
    load_fib();
    go();
    t_prev = 0;
    for (int n = 0; n < 8; n++) begin
      wait_out(d, t, got);
      check(got && d == fib[n], $sformatf("R8 sequence term %0d", n), d, fib[n]);
      if (n > 0) begin
        exp = (n % 2 == 1) ? 16'd9 : 16'd12;
        check(DW'(t - t_prev) == exp, $sformatf("R13 output spacing %0d", n),
              DW'(t - t_prev), exp);
      end
      t_prev = t;
      @(negedge clk);
      check(!out_valid, "R9 single-cycle valid", {15'd0, out_valid}, '0);
    end

    // R9: back-pressure holds the word
    load_fib();
    out_ready = 1'b0;
    go();
    wait_out(d, t, got);
    check(got && d == 16'd1, "R9 first word under stall", d, 16'd1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid && out_data == 16'd1, "R9 held while stalled", out_data, 16'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R9 valid drops after transfer", {15'd0, out_valid}, '0);
    wait_out(d, t, got);
    check(got && d == 16'd2, "R9 next word after stall", d, 16'd2);

    // R6 R2: stores of both registers, read back through loads
    hold_and_clear();
    wr(0, ins(0, 20));
    wr(1, ins(1, 22));
    wr(2, ins(8, 22));
    wr(3, ins(15, 0));
    wr(4, ins(13, 0));
    wr(5, ins(9, 24));
    wr(6, ins(0, 24));
    wr(7, ins(14, 0));
    wr(8, ins(7, 0));
    wr(20, 16'h3C5A);
    go();
    wait_out(d, t, got);
    check(got && d == 16'h3C5A, "R6 store r1", d, 16'h3C5A);
    wait_out(d, t, got);
    check(got && d == 16'hC3A5, "R6 store r2", d, 16'hC3A5);

    // R7: conditional jump on register 1, taken and not taken
    for (int c = 0; c < 2; c++) begin
      hold_and_clear();
      wr(0, ins(0, 20));
      wr(1, ins(2, 4));
      wr(2, ins(14, 0));
      wr(3, ins(7, 0));
      wr(4, ins(8, 21));
      wr(5, ins(15, 0));
      wr(6, ins(7, 0));
      wr(20, (c == 0) ? 16'h0000 : 16'h0005);
      wr(21, 16'h1234);
      go();
      exp = (c == 0) ? 16'h1234 : 16'h0005;
      wait_out(d, t, got);
      check(got && d == exp, $sformatf("R7 jz r1 case %0d", c), d, exp);
    end

    // R7: unconditional jump
    hold_and_clear();
    wr(0, ins(6, 5));
    wr(1, ins(14, 0));
    wr(2, ins(7, 0));
    wr(5, ins(0, 20));
    wr(6, ins(6, 1));
    wr(20, 16'h0BAD);
    go();
    wait_out(d, t, got);
    check(got && d == 16'h0BAD, "R7 jump", d, 16'h0BAD);

    // R12 R7: jz on register 2 to 62, counter wraps, second jz falls through
    hold_and_clear();
    wr(0, ins(10, 62));
    wr(1, ins(14, 0));
    wr(2, ins(7, 0));
    wr(62, ins(8, 20));
    wr(63, ins(17, 0));
    wr(20, 16'h0007);
    go();
    wait_out(d, t, got);
    check(got && d == 16'h0001, "R12 wrap 63 to 0", d, 16'h0001);

    // R10: halted is sticky and silent
    wait_halt(got);
    check(got, "R10 halted", {15'd0, halted}, 16'd1);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!halted || out_valid) begin
        check(1'b0, "R10 stays halted", {14'd0, halted, out_valid}, 16'd2);
        break;
      end
    end

    // R1: reset clears registers and halt, memory survives
    hold_and_clear();
    wr(0, ins(14, 0));
    wr(1, ins(15, 0));
    wr(2, ins(0, 20));
    wr(3, ins(8, 21));
    wr(4, ins(14, 0));
    wr(5, ins(7, 0));
    wr(20, 16'h1111);
    wr(21, 16'h2222);
    go();
    for (int r = 0; r < 2; r++) begin
      wait_out(d, t, got);
      check(got && d == 16'h0000, $sformatf("R1 r1 clear pass %0d", r), d, 16'h0000);
      wait_out(d, t, got);
      check(got && d == 16'h0000, $sformatf("R1 r2 clear pass %0d", r), d, 16'h0000);
      wait_out(d, t, got);
      check(got && d == 16'h1111, $sformatf("R1 program kept pass %0d", r), d, 16'h1111);
      wait_halt(got);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(!halted && !out_valid, "R1 halt cleared by reset",
            {14'd0, halted, out_valid}, '0);
      rst = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule